// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of function 0 of a host-to-PCI bridge. A byte-wide port writes one register per clock and reads any register combinationally. Every write passes through a per-address filter: some address ranges are read-only, the command byte exposes a single writable bit, and the status byte clears bits when ones are written to them. Identification and capability bytes are loaded with fixed values on reset.

The block also drives the graphics aperture outputs from its registers: base address, size in megabytes, enable, and the base of the address translation table. Whenever a register feeding the aperture is written, the base is cut back in the same clock edge so that it stays aligned to the programmed size. Accesses to any other function number read as all ones and never change state.

Top module: `hb_cfg_space`

## Requirements
- R1: After reset, bytes 0x00=0x06, 0x01=0x11, 0x04=0x06, 0x07=0x02, 0x0B=0x06, 0x34=0xA0, each of 0x5A..0x5F=0x01, and every other byte reads 0x00.
- R2: Writes to 0x00-0x03, 0x06, 0x08-0x0C, 0x0E, 0x10-0x11, 0x14-0x4F, 0x7B-0x7D, 0x81-0x83, 0x85-0x87, 0x8C-0xA7, 0xAA-0xAB, 0xAE-0xEF and 0xF8-0xFB leave the byte unchanged.
- R3: At byte 0x07, a written 1 in bit 7, 5 or 4 clears that stored bit; written zeros and all other bit positions leave the stored value unchanged.
- R4: At byte 0x04 only bit 6 takes the written value; the other seven bits keep their reset value.
- R5: Byte 0x12 stores only its upper nibble (low nibble reads 0); the aperture base output is {byte 0x13, byte 0x12, 16'h0000}.
- R6: In the same edge as any write to 0x12, 0x13, 0x84, 0x88, 0x89, 0x8A or 0x8B, byte 0x12 becomes itself AND {byte 0x84[3:0], 4'h0} and byte 0x13 becomes itself AND {4'hF, byte 0x84[7:4]}, using the post-write values.
- R7: The aperture size output, in megabytes, is (bitwise NOT of byte 0x84) + 1 as a 9-bit value (byte 0x84=0x00 gives 256).
- R8: The aperture enable output equals bit 1 of byte 0x88; the translation table base output is {byte 0x8B, byte 0x8A, byte 0x89, 8'h00}, and byte 0x89 stores only its upper nibble.
- R9: When the function number is not 0, reads return 0xFF and writes change nothing.
- R10: Every byte not covered by R2-R5 or R8 is fully writable, and a read of function 0 returns the stored byte in the same cycle as the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Register byte address |
| cfg_wr | input | 1 | Write strobe, one byte per cycle |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data |
| aper_base | output | 32 | Aperture base address |
| aper_size_mb | output | 9 | Aperture size in megabytes |
| aper_en | output | 1 | Aperture enable |
| gart_base | output | 32 | Translation table base address |

## Verification
On every cycle the assertions check that a write into a read-only range leaves the byte as it was, that the status byte only ever loses bits, that the command byte keeps its fixed bits, that the aperture base never has bits set below its size, and that other functions read as all ones. Only the bench's scenarios show the exact values that reads return after chains of writes, such as the base being trimmed when the size register later grows, the low nibbles being dropped, and the decoded size, enable and table base words.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_CMD    = 8'h04;
  localparam logic [ADDR_W-1:0] A_STS    = 8'h07;
  localparam logic [ADDR_W-1:0] A_APB_LO = 8'h12;
  localparam logic [ADDR_W-1:0] A_APB_HI = 8'h13;
  localparam logic [ADDR_W-1:0] A_APSIZE = 8'h84;
  localparam logic [ADDR_W-1:0] A_APCTL  = 8'h88;
  localparam logic [ADDR_W-1:0] A_TT0    = 8'h89;
  localparam logic [ADDR_W-1:0] A_TT1    = 8'h8A;
  localparam logic [ADDR_W-1:0] A_TT2    = 8'h8B;

  localparam logic [DATA_W-1:0] STS_CLR_BITS = 8'hB0;

  // Address ranges where stores are discarded
  function automatic logic is_ro(input logic [ADDR_W-1:0] a);
    return (a <= 8'h03) || (a == 8'h06) ||
           (a >= 8'h08 && a <= 8'h0C) || (a == 8'h0E) ||
           (a >= 8'h10 && a <= 8'h11) || (a >= 8'h14 && a <= 8'h4F) ||
           (a >= 8'h7B && a <= 8'h7D) || (a >= 8'h81 && a <= 8'h83) ||
           (a >= 8'h85 && a <= 8'h87) || (a >= 8'h8C && a <= 8'hA7) ||
           (a >= 8'hAA && a <= 8'hAB) || (a >= 8'hAE && a <= 8'hEF) ||
           (a >= 8'hF8 && a <= 8'hFB);
  endfunction

  // Bits that take written data directly
  function automatic logic [DATA_W-1:0] wr_mask(input logic [ADDR_W-1:0] a);
    if (is_ro(a))            return '0;
    else if (a == A_CMD)     return 8'h40;
    else if (a == A_STS)     return '0;
    else if (a == A_APB_LO)  return 8'hF0;
    else if (a == A_TT0)     return 8'hF0;
    else                     return '1;
  endfunction

  function automatic logic [DATA_W-1:0] rst_val(input logic [ADDR_W-1:0] a);
    case (a)
      8'h00:   return 8'h06;
      8'h01:   return 8'h11;
      8'h04:   return 8'h06;
      8'h07:   return 8'h02;
      8'h0B:   return 8'h06;
      8'h34:   return 8'hA0;
      default: return (a >= 8'h5A && a <= 8'h5F) ? 8'h01 : 8'h00;
    endcase
  endfunction

  function automatic logic aper_touch(input logic [ADDR_W-1:0] a);
    return (a == A_APB_LO) || (a == A_APB_HI) || (a == A_APSIZE) ||
           (a == A_APCTL) || (a == A_TT0) || (a == A_TT1) || (a == A_TT2);
  endfunction

  function automatic logic [DATA_W-1:0] align_lo(input logic [DATA_W-1:0] b,
                                                 input logic [DATA_W-1:0] sz);
    return b & {sz[3:0], 4'h0};
  endfunction

  function automatic logic [DATA_W-1:0] align_hi(input logic [DATA_W-1:0] b,
                                                 input logic [DATA_W-1:0] sz);
    return b & {4'hF, sz[7:4]};
  endfunction

  function automatic logic [DATA_W:0] aper_mb(input logic [DATA_W-1:0] sz);
    return {1'b0, ~sz} + {{DATA_W{1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/hb_cfg_wfilter.sv
module hb_cfg_wfilter
  import hb_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] old_byte,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] new_byte,
  output logic              ro_hit
);
  logic [DATA_W-1:0] m;

  always_comb begin
    m      = wr_mask(addr);
    ro_hit = is_ro(addr);
    if (addr == A_STS)
      new_byte = old_byte & ~(wdata & STS_CLR_BITS);
    else
      new_byte = (old_byte & ~m) | (wdata & m);
  end
endmodule

// File: rtl/hb_cfg_store.sv
module hb_cfg_store
  import hb_cfg_pkg::*;
#(
  parameter int NREGS = NUM_REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] regs_q [NREGS]
);
  logic [DATA_W-1:0] nxt [NREGS];
  logic [DATA_W-1:0] sel_old;
  logic [DATA_W-1:0] filt_byte;
  logic              ro_hit;
  logic              touch;

  assign sel_old = regs_q[addr];
  assign touch   = wr_fire && aper_touch(addr);

  hb_cfg_wfilter u_filt (
    .addr     (addr),
    .old_byte (sel_old),
    .wdata    (wdata),
    .new_byte (filt_byte),
    .ro_hit   (ro_hit)
  );

  always_comb begin
    nxt = regs_q;
    if (wr_fire) nxt[addr] = filt_byte;
    if (touch) begin
      nxt[A_APB_LO] = align_lo(nxt[A_APB_LO], nxt[A_APSIZE]);
      nxt[A_APB_HI] = align_hi(nxt[A_APB_HI], nxt[A_APSIZE]);
    end
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= rst_val(IDX);
      else        regs_q[i] <= nxt[i];
    end
  end

  // Snapshot of the previous access for the checks below
  logic              chk_ro_wr, chk_sts_wr;
  logic [ADDR_W-1:0] chk_addr;
  logic [DATA_W-1:0] chk_old, chk_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_ro_wr  <= 1'b0;
      chk_sts_wr <= 1'b0;
      chk_addr   <= '0;
      chk_old    <= '0;
      chk_wdata  <= '0;
    end else begin
      chk_ro_wr  <= wr_fire && ro_hit;
      chk_sts_wr <= wr_fire && (addr == A_STS);
      chk_addr   <= addr;
      chk_old    <= sel_old;
      chk_wdata  <= wdata;
    end
  end

  assert_ro_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ro_wr |-> (regs_q[chk_addr] == chk_old));

  assert_sts_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_sts_wr |-> (((regs_q[A_STS] & ~chk_old) == '0) &&
                    (((regs_q[A_STS] ^ chk_old) & ~(chk_wdata & STS_CLR_BITS)) == '0)));

  assert_cmd_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((regs_q[A_CMD] & 8'hBF) == 8'h06));
endmodule

// File: rtl/hb_aper_decode.sv
module hb_aper_decode
  import hb_cfg_pkg::*;
(
  input  logic [DATA_W-1:0] b_lo,
  input  logic [DATA_W-1:0] b_hi,
  input  logic [DATA_W-1:0] b_size,
  input  logic              en_bit,
  input  logic [DATA_W-1:0] tt0,
  input  logic [DATA_W-1:0] tt1,
  input  logic [DATA_W-1:0] tt2,
  output logic [31:0]       base,
  output logic [DATA_W:0]   size_mb,
  output logic              en,
  output logic [31:0]       tt_base
);
  assign base    = {b_hi, b_lo, 16'h0000};
  assign size_mb = aper_mb(b_size);
  assign en      = en_bit;
  assign tt_base = {tt2, tt1, tt0, 8'h00};
endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
  import hb_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_func,
  input  logic [7:0]  cfg_addr,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  output logic [31:0] aper_base,
  output logic [8:0]  aper_size_mb,
  output logic        aper_en,
  output logic [31:0] gart_base
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              func0;
  logic              wr_fire;

  assign func0   = (cfg_func == 3'd0);
  assign wr_fire = cfg_wr && func0;

  hb_cfg_store #(.NREGS(NUM_REGS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .regs_q  (regs_q)
  );

  hb_aper_decode u_aper (
    .b_lo    (regs_q[A_APB_LO]),
    .b_hi    (regs_q[A_APB_HI]),
    .b_size  (regs_q[A_APSIZE]),
    .en_bit  (regs_q[A_APCTL][1]),
    .tt0     (regs_q[A_TT0]),
    .tt1     (regs_q[A_TT1]),
    .tt2     (regs_q[A_TT2]),
    .base    (aper_base),
    .size_mb (aper_size_mb),
    .en      (aper_en),
    .tt_base (gart_base)
  );

  assign cfg_rdata = func0 ? regs_q[cfg_addr] : 8'hFF;

  assert_base_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((aper_base[23:20] & ~regs_q[A_APSIZE][3:0]) == 4'h0) &&
    ((aper_base[27:24] & ~regs_q[A_APSIZE][7:4]) == 4'h0));

  assert_other_func_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_func != 3'd0) |-> (cfg_rdata == 8'hFF));
endmodule

// File: tb/hb_cfg_space_tb.sv
module hb_cfg_space_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_func = '0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [31:0] aper_base;
  logic [8:0]  aper_size_mb;
  logic        aper_en;
  logic [31:0] gart_base;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hb_cfg_space dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .aper_base(aper_base), .aper_size_mb(aper_size_mb), .aper_en(aper_en),
    .gart_base(gart_base)
  );

  // Entry: {req, func, wr, addr, wdata, expected read of func 0 at addr}
  localparam int NV = 30;
  localparam logic [31:0] VEC [NV] = '{
    {4'd1,  3'd0, 1'b0, 8'h00, 8'h00, 8'h06},
    {4'd1,  3'd0, 1'b0, 8'h01, 8'h00, 8'h11},
    {4'd1,  3'd0, 1'b0, 8'h04, 8'h00, 8'h06},
    {4'd1,  3'd0, 1'b0, 8'h07, 8'h00, 8'h02},
    {4'd1,  3'd0, 1'b0, 8'h0B, 8'h00, 8'h06},
    {4'd1,  3'd0, 1'b0, 8'h34, 8'h00, 8'hA0},
    {4'd1,  3'd0, 1'b0, 8'h5C, 8'h00, 8'h01},
    {4'd1,  3'd0, 1'b0, 8'h20, 8'h00, 8'h00},
    {4'd2,  3'd0, 1'b1, 8'h00, 8'h55, 8'h06},
    {4'd2,  3'd0, 1'b1, 8'h34, 8'hFF, 8'hA0},
    {4'd2,  3'd0, 1'b1, 8'h90, 8'h12, 8'h00},
    {4'd2,  3'd0, 1'b1, 8'hF9, 8'h77, 8'h00},
    {4'd4,  3'd0, 1'b1, 8'h04, 8'hFF, 8'h46},
    {4'd4,  3'd0, 1'b1, 8'h04, 8'h00, 8'h06},
    {4'd3,  3'd0, 1'b1, 8'h07, 8'hFF, 8'h02},
    {4'd3,  3'd0, 1'b1, 8'h07, 8'h00, 8'h02},
    {4'd10, 3'd0, 1'b1, 8'h50, 8'hA5, 8'hA5},
    {4'd10, 3'd0, 1'b1, 8'hFD, 8'h3C, 8'h3C},
    {4'd9,  3'd1, 1'b1, 8'h50, 8'h00, 8'hA5},
    {4'd9,  3'd5, 1'b1, 8'hFD, 8'hFF, 8'h3C},
    {4'd7,  3'd0, 1'b1, 8'h84, 8'hF0, 8'hF0},
    {4'd6,  3'd0, 1'b1, 8'h13, 8'hFF, 8'hFF},
    {4'd6,  3'd0, 1'b1, 8'h12, 8'hFF, 8'h00},
    {4'd6,  3'd0, 1'b1, 8'h84, 8'hC0, 8'hC0},
    {4'd6,  3'd0, 1'b0, 8'h13, 8'h00, 8'hFC},
    {4'd7,  3'd0, 1'b1, 8'h84, 8'hFF, 8'hFF},
    {4'd5,  3'd0, 1'b1, 8'h12, 8'hAB, 8'hA0},
    {4'd8,  3'd0, 1'b1, 8'h89, 8'h5F, 8'h50},
    {4'd8,  3'd0, 1'b1, 8'h8A, 8'h34, 8'h34},
    {4'd8,  3'd0, 1'b1, 8'h8B, 8'h12, 8'h12}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic read0(input logic [7:0] a, output logic [7:0] d);
    cfg_func = 3'd0; cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][31:28], i);
      if (VEC[i][24]) do_write(VEC[i][27:25], VEC[i][23:16], VEC[i][15:8]);
      read0(VEC[i][23:16], rd);
      check(tag, {24'h0, rd}, {24'h0, VEC[i][7:0]});
    end

    // R5 R7: base after trimming, 1 MB size
    check("R5 aper_base", aper_base, 32'hFCA0_0000);
    check("R7 size 1MB", {23'h0, aper_size_mb}, 32'd1);
    // R8: table base and enable
    check("R8 gart_base", gart_base, 32'h1234_5000);
    check("R8 enable off", {31'h0, aper_en}, 32'd0);
    do_write(3'd0, 8'h88, 8'h02);
    check("R8 enable on", {31'h0, aper_en}, 32'd1);
    // R6: widest size trims both bytes
    do_write(3'd0, 8'h84, 8'h00);
    check("R7 size 256MB", {23'h0, aper_size_mb}, 32'd256);
    check("R6 base trimmed", aper_base, 32'hF000_0000);
    do_write(3'd0, 8'h84, 8'hE0);
    check("R7 size 32MB", {23'h0, aper_size_mb}, 32'd32);
    // R9: other function reads all ones
    cfg_func = 3'd2; cfg_addr = 8'h00; #1;
    check("R9 read func2", {24'h0, cfg_rdata}, 32'hFF);
    // R10: same-cycle read of a fresh address
    read0(8'h50, rd);
    check("R10 comb read", {24'h0, rd}, 32'hA5);
    // R1: reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read0(8'h50, rd);
    check("R1 reset clears 0x50", {24'h0, rd}, 32'h00);
    read0(8'h5F, rd);
    check("R1 reset 0x5F", {24'h0, rd}, 32'h01);
    check("R1 reset size", {23'h0, aper_size_mb}, 32'd256);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule